// File: doc/BRIEF.md
# Two-Level ALU Operation Decoder

This block is the second stage of ALU decoding in a single-issue integer pipeline. The main instruction decoder looks only at the opcode and sends a 3-bit operation class to this block. For every class except one reserved value, that class already names the ALU operation, and this block forwards it unchanged. When the main decoder marks an instruction as register-to-register, it sends the reserved value. This block then reads the 6-bit function field of the instruction to pick the operation.

The output is a 4-bit select for an ALU with these operations: add, subtract, AND, OR, XOR, NOR, set-less-than, and three barrel-shifter operations (shift left logical, shift right logical, shift right arithmetic). The block also raises a flag for register-indirect jumps, so the PC logic can redirect. It raises a second flag for a function code it does not recognise. The block is purely combinational and has no clock or reset.

Top module: `alu_ctrl_decoder`

## Requirements
- R1: When `alu_op_i` is not 3'b111, `op_o` equals `alu_op_i` zero-extended to 4 bits. The operation encodings are ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, SLT=6, SLL=7, SRL=8, SRA=9.
- R2: When `alu_op_i` is 3'b111, function codes 0x20 and 0x21 select ADD (0).
- R3: When `alu_op_i` is 3'b111, function codes 0x22 and 0x23 select SUB (1).
- R4: When `alu_op_i` is 3'b111, function codes 0x24, 0x25, 0x26 and 0x27 select AND (2), OR (3), XOR (4) and NOR (5) respectively.
- R5: When `alu_op_i` is 3'b111, function code 0x2A selects SLT (6).
- R6: When `alu_op_i` is 3'b111, function codes 0x00, 0x02 and 0x03 select SLL (7), SRL (8) and SRA (9). A shift select never appears for any other `alu_op_i`.
- R7: When `alu_op_i` is 3'b111, function codes 0x08 and 0x09 raise `reg_jump_o` and select ADD.
- R8: When `alu_op_i` is 3'b111 and the function code is not one listed in R2 to R7, `illegal_fn_o` is raised and `op_o` is ADD.
- R9: `reg_jump_o` and `illegal_fn_o` are never high together. Both are low whenever `alu_op_i` is not 3'b111.
- R10: When `alu_op_i` is not 3'b111, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op_i | input | 3 | Operation class from the main decoder; 3'b111 means register-to-register |
| funct_i | input | 6 | Function field of the current instruction |
| op_o | output | 4 | ALU and shifter operation select |
| reg_jump_o | output | 1 | Register-indirect jump detected |
| illegal_fn_o | output | 1 | Unrecognised function code under the register-to-register class |

## Verification
The block holds no state, so a fault in its decode paths shows at the ports in the same evaluation that the inputs change. A wrong table entry gives the wrong operation select for one specific function code. A fault in the class comparison makes the outputs depend on the function field when they should not, or raises flags outside the register-to-register class. The bench drives every class value against every function code, and then adds random mixes. A fault in any single entry therefore shows up on the first input pair that reaches it.

// File: rtl/alu_ctrl_pkg.sv
package alu_ctrl_pkg;
  localparam int ALUOP_W = 3;
  localparam int FUNCT_W = 6;
  localparam int OP_W    = 4;

  localparam logic [ALUOP_W-1:0] RTYPE_CLASS = 3'b111;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOR = 4'd5,
    OP_SLT = 4'd6,
    OP_SLL = 4'd7,
    OP_SRL = 4'd8,
    OP_SRA = 4'd9
  } alu_sel_e;

  typedef struct packed {
    logic     jump;
    logic     illegal;
    alu_sel_e sel;
  } fn_dec_t;
endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_ctrl_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct_i,
  output fn_dec_t            dec_o
);
  always_comb begin
    dec_o = '{jump: 1'b0, illegal: 1'b0, sel: OP_ADD};
    unique case (funct_i)
      6'h20, 6'h21: dec_o.sel = OP_ADD;
      6'h22, 6'h23: dec_o.sel = OP_SUB;
      6'h24:        dec_o.sel = OP_AND;
      6'h25:        dec_o.sel = OP_OR;
      6'h26:        dec_o.sel = OP_XOR;
      6'h27:        dec_o.sel = OP_NOR;
      6'h2A:        dec_o.sel = OP_SLT;
      6'h00:        dec_o.sel = OP_SLL;
      6'h02:        dec_o.sel = OP_SRL;
      6'h03:        dec_o.sel = OP_SRA;
      6'h08, 6'h09: dec_o.jump = 1'b1;
      default:      dec_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_op_select.sv
module alu_op_select
  import alu_ctrl_pkg::*;
(
  input  logic [ALUOP_W-1:0] alu_op_i,
  input  fn_dec_t            dec_i,
  output logic [OP_W-1:0]    op_o,
  output logic               reg_jump_o,
  output logic               illegal_fn_o
);
  localparam int PAD_W = OP_W - ALUOP_W;

  logic              is_rtype;
  logic [OP_W-1:0]   pass_op;

  generate
    if (PAD_W > 0) begin : g_pad
      assign pass_op = {{PAD_W{1'b0}}, alu_op_i};
    end else begin : g_nopad
      assign pass_op = alu_op_i[OP_W-1:0];
    end
  endgenerate

  assign is_rtype     = (alu_op_i == RTYPE_CLASS);
  assign op_o         = is_rtype ? dec_i.sel : pass_op;
  assign reg_jump_o   = is_rtype & dec_i.jump;
  assign illegal_fn_o = is_rtype & dec_i.illegal;
endmodule

// File: rtl/alu_ctrl_decoder.sv
module alu_ctrl_decoder
  import alu_ctrl_pkg::*;
(
  input  logic [2:0] alu_op_i,
  input  logic [5:0] funct_i,
  output logic [3:0] op_o,
  output logic       reg_jump_o,
  output logic       illegal_fn_o
);
  fn_dec_t fn_dec;

  alu_fn_decode u_fn (
    .funct_i (funct_i),
    .dec_o   (fn_dec)
  );

  alu_op_select u_sel (
    .alu_op_i     (alu_op_i),
    .dec_i        (fn_dec),
    .op_o         (op_o),
    .reg_jump_o   (reg_jump_o),
    .illegal_fn_o (illegal_fn_o)
  );

  always_comb begin
    if (alu_op_i != RTYPE_CLASS) begin
      assert_passthru_R1: assert (op_o == {1'b0, alu_op_i})
        else $error("pass-through class altered");
      assert_no_flags_R9: assert (!reg_jump_o && !illegal_fn_o)
        else $error("flag raised outside register class");
      assert_no_shift_R6: assert (op_o < OP_SLL)
        else $error("shift selected outside register class");
    end
    if (reg_jump_o) begin
      assert_jump_add_R7: assert (op_o == OP_ADD)
        else $error("register jump without add");
    end
    if (illegal_fn_o) begin
      assert_illegal_add_R8: assert (op_o == OP_ADD)
        else $error("illegal code without add default");
    end
    assert_flags_excl_R9: assert (!(reg_jump_o && illegal_fn_o))
      else $error("both flags high");
  end
endmodule

// File: tb/alu_ctrl_decoder_tb.sv
module alu_ctrl_decoder_tb_top;
  logic       clk = 1'b0;
  logic [2:0] alu_op;
  logic [5:0] funct;
  logic [3:0] op;
  logic       rj, ill;
  int         n_run = 0, n_fail = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu_ctrl_decoder dut_i (
    .alu_op_i     (alu_op),
    .funct_i      (funct),
    .op_o         (op),
    .reg_jump_o   (rj),
    .illegal_fn_o (ill)
  );

  // returns {jump, illegal, op}
  function automatic logic [5:0] model(input logic [2:0] a, input logic [5:0] f);
    if (a != 3'b111) return {2'b00, 1'b0, a};
    case (f)
      6'h20, 6'h21: return 6'd0;
      6'h22, 6'h23: return 6'd1;
      6'h24: return 6'd2;
      6'h25: return 6'd3;
      6'h26: return 6'd4;
      6'h27: return 6'd5;
      6'h2A: return 6'd6;
      6'h00: return 6'd7;
      6'h02: return 6'd8;
      6'h03: return 6'd9;
      6'h08, 6'h09: return {2'b10, 4'd0};
      default: return {2'b01, 4'd0};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a, input logic [5:0] f);
    if (a != 3'b111) return "R1/R10";
    case (f)
      6'h20, 6'h21: return "R2";
      6'h22, 6'h23: return "R3";
      6'h24, 6'h25, 6'h26, 6'h27: return "R4";
      6'h2A: return "R5";
      6'h00, 6'h02, 6'h03: return "R6";
      6'h08, 6'h09: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [2:0] a, input logic [5:0] f);
    logic [5:0] exp;
    @(negedge clk);
    alu_op = a;
    funct  = f;
    #2;
    exp = model(a, f);
    n_run++;
    if ({rj, ill, op} !== exp) begin
      n_fail++;
      $display("FAIL %s aluop=%0d funct=%02h got {jump,ill,op}=%b expected %b",
               req_of(a, f), a, f, {rj, ill, op}, exp);
    end
    // R9: flags exclusive and silent outside register class
    n_run++;
    if ((rj && ill) || (a != 3'b111 && (rj || ill))) begin
      n_fail++;
      $display("FAIL R9 aluop=%0d funct=%02h got jump=%b ill=%b expected exclusive/low",
               a, f, rj, ill);
    end
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // Directed corner cases: R2..R8 listed codes
    apply(3'b111, 6'h20); apply(3'b111, 6'h21);   // R2
    apply(3'b111, 6'h22); apply(3'b111, 6'h23);   // R3
    apply(3'b111, 6'h24); apply(3'b111, 6'h27);   // R4
    apply(3'b111, 6'h2A);                         // R5
    apply(3'b111, 6'h00); apply(3'b111, 6'h03);   // R6
    apply(3'b111, 6'h08); apply(3'b111, 6'h09);   // R7
    apply(3'b111, 6'h01); apply(3'b111, 6'h3F);   // R8
    // Exhaustive: every class against every function code (R1, R10, R9)
    for (int a = 0; a < 8; a++)
      for (int f = 0; f < 64; f++)
        apply(a[2:0], f[5:0]);
    // Random mix biased toward the register class
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a;
      a = ($urandom % 2) ? 3'b111 : 3'($urandom);
      apply(a, 6'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule